// File: doc/BRIEF.md
# Indirect Memory Access Engine

This block lets a narrow host port reach several wide internal memories without mapping them into the host address space. The host first fills a 32-bit holding register elsewhere. It then issues a commit that carries a small internal index. A commit to the configuration index sets the target memory, the direction and the address mode. A commit to the address index loads the entry address. A commit to the buffer index (15) moves the holding register into the memory word buffer, or triggers a read.

Coefficient entries are 72 bits wide, so each entry is assembled from three 32-bit pieces. A two-bit word-select counter tracks which piece comes next. The memory is written when the final piece arrives. On a read commit, the addressed entry is captured whole into a readback buffer, and the host picks one 32-bit piece of it at a time. The memories themselves are plain RAMs. The 256x32 sample store is written only from a separate producer port and is read-only through the host path.

Top module: `mem_tunnel`

## Requirements
- R1: A commit to index 0 loads the memory configuration from the holding register: bit 6 = auto-increment (1) or manual address (0); bit 5 = read (1) or write (0); bits [4:2] = target: 001 coefficient I (64x72), 010 coefficient Q (64x72), 011 both coefficient RAMs, 100 symbol map (256x8), 101 sample store (256x32). For codes 000, 110 and 111, a commit to index 15 changes no memory and no readback.
- R2: In write mode with a coefficient target, piece 0 supplies entry bits [31:0] and piece 1 supplies bits [63:32]. Piece 2 supplies bits [71:64] from its low byte; its upper 24 bits are ignored. The RAM write takes place on piece 2, and the word select then returns to 0.
- R3: A commit to index 0 loads the word select from holding bits [1:0]. Pieces that are skipped by a non-zero start keep their last assembled values.
- R4: Target 011 writes the same assembled entry into both coefficient RAMs at the same address.
- R5: With the symbol map target, every index-15 write commit stores holding bits [7:0] as one complete entry.
- R6: Index-15 write commits to the sample store are ignored: the store is not written and the address does not move. Reads of the sample store return the data from the producer port.
- R7: In auto-increment mode the address rises by one after each completed entry, whether written or read. The address wraps modulo 256, and coefficient RAMs use its low 6 bits.
- R8: In manual mode the address changes only on a commit to index 1, which loads it from holding bits [7:0].
- R9: A read commit to index 15 captures the addressed entry into the readback buffer. Target 011 reads the I RAM. rd_piece_i selects bits [31:0] (0), [63:32] (1), or [71:64] zero-extended (2); selection 3 returns zero. Narrower entries are zero-extended. The buffer does not change at any other time.
- R10: After reset the configuration is all zero (no target, write, manual), the address is 0, the word select is 0 and the readback buffer is 0.
- R11: Commits to indices other than 0, 1 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | Commit strobe, one cycle per commit |
| commit_idx_i | input | 4 | Internal index of the commit |
| hold_i | input | 32 | Holding register contents |
| rd_piece_i | input | 2 | Readback piece select |
| rd_data_o | output | 32 | Selected readback piece |
| fifo_we_i | input | 1 | Producer write enable for the sample store |
| fifo_waddr_i | input | 8 | Producer write address |
| fifo_wdata_i | input | 32 | Producer write data |

## Verification
Every commit is registered on a single rising edge. RAM writes, address and word-select updates and the readback capture are all in place after that edge. rd_data_o is a pure selection from the readback buffer, so a new piece appears combinationally whenever rd_piece_i changes. The bench drives each commit on a falling edge and removes it on the next falling edge. It then steps through the four pieces in half-nanosecond steps, well before the next rising edge. Every expectation therefore refers to the state left by exactly one commit edge.

// File: rtl/mt_pkg.sv
package mt_pkg;

   typedef enum logic [2:0] {
      TGT_NONE    = 3'b000,
      TGT_COEF_I  = 3'b001,
      TGT_COEF_Q  = 3'b010,
      TGT_COEF_IQ = 3'b011,
      TGT_MAP     = 3'b100,
      TGT_FIFO    = 3'b101,
      TGT_RSV6    = 3'b110,
      TGT_RSV7    = 3'b111
   } tgt_e;

   // Packed order matches holding bits [6:2]
   typedef struct packed {
      logic auto_inc;
      logic dir_rd;
      tgt_e tgt;
   } mem_cfg_t;

   function automatic logic is_wide(input tgt_e t);
      return (t == TGT_COEF_I) || (t == TGT_COEF_Q) || (t == TGT_COEF_IQ);
   endfunction

   function automatic logic is_readable(input tgt_e t);
      return is_wide(t) || (t == TGT_MAP) || (t == TGT_FIFO);
   endfunction

endpackage

// File: rtl/mt_ram.sv
module mt_ram #(
   parameter int W     = 32,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl
   import mt_pkg::*;
#(
   parameter int HOLD_W   = 32,
   parameter int WIDE_W   = 72,
   parameter int AW       = 8,
   parameter int IDX_W    = 4,
   parameter int CFG_IDX  = 0,
   parameter int ADDR_IDX = 1,
   parameter int BUF_IDX  = 15,
   localparam int PIECES  = (WIDE_W + HOLD_W - 1) / HOLD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [HOLD_W-1:0] hold_i,
   output mem_cfg_t          cfg_o,
   output logic [1:0]        wsel_o,
   output logic [AW-1:0]     addr_o,
   output logic [1:0]        coef_we_o,
   output logic              map_we_o,
   output logic [WIDE_W-1:0] wdata_o,
   output logic              rd_stb_o
);

   localparam int ASM_W = PIECES * HOLD_W;
   localparam logic [1:0] LAST_SEL = 2'(PIECES - 1);

   mem_cfg_t          cfg_q;
   logic [1:0]        wsel_q;
   logic [AW-1:0]     addr_q;
   logic [ASM_W-1:0]  asm_q;
   logic [ASM_W-1:0]  asm_next;
   logic              cfg_hit, addr_hit, buf_hit;
   logic              wide_tgt, last_piece, wr_req;
   logic              wide_done, map_wr, rd_go, entry_done;

   assign cfg_hit  = commit_i && (idx_i == IDX_W'(CFG_IDX));
   assign addr_hit = commit_i && (idx_i == IDX_W'(ADDR_IDX));
   assign buf_hit  = commit_i && (idx_i == IDX_W'(BUF_IDX));

   assign wide_tgt   = is_wide(cfg_q.tgt);
   assign last_piece = (wsel_q >= LAST_SEL);
   assign wr_req     = buf_hit && !cfg_q.dir_rd;

   // Overlay the incoming piece on the retained assembly
   for (genvar p = 0; p < PIECES; p++) begin : g_piece
      assign asm_next[p*HOLD_W +: HOLD_W] =
         (wsel_q == 2'(p)) ? hold_i : asm_q[p*HOLD_W +: HOLD_W];
   end

   assign wide_done  = wr_req && wide_tgt && last_piece;
   assign map_wr     = wr_req && (cfg_q.tgt == TGT_MAP);
   assign rd_go      = buf_hit && cfg_q.dir_rd && is_readable(cfg_q.tgt);
   assign entry_done = wide_done || map_wr || rd_go;

   assign coef_we_o[0] = wide_done &&
                         ((cfg_q.tgt == TGT_COEF_I) || (cfg_q.tgt == TGT_COEF_IQ));
   assign coef_we_o[1] = wide_done &&
                         ((cfg_q.tgt == TGT_COEF_Q) || (cfg_q.tgt == TGT_COEF_IQ));
   assign map_we_o     = map_wr;
   assign rd_stb_o     = rd_go;
   assign wdata_o      = asm_next[WIDE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         wsel_q <= '0;
         addr_q <= '0;
         asm_q  <= '0;
      end else begin
         if (cfg_hit) begin
            cfg_q  <= mem_cfg_t'(hold_i[6:2]);
            wsel_q <= hold_i[1:0];
         end
         if (addr_hit) begin
            addr_q <= hold_i[AW-1:0];
         end else if (entry_done && cfg_q.auto_inc) begin
            addr_q <= addr_q + 1'b1;
         end
         if (wr_req && wide_tgt) begin
            asm_q  <= asm_next;
            wsel_q <= last_piece ? 2'd0 : wsel_q + 2'd1;
         end
      end
   end

   assign cfg_o  = cfg_q;
   assign wsel_o = wsel_q;
   assign addr_o = addr_q;

endmodule

// File: rtl/mem_tunnel.sv
module mem_tunnel
   import mt_pkg::*;
#(
   parameter int HOLD_W     = 32,
   parameter int COEF_W     = 72,
   parameter int COEF_DEPTH = 64,
   parameter int MAP_W      = 8,
   parameter int MAP_DEPTH  = 256,
   parameter int FIFO_W     = 32,
   parameter int FIFO_DEPTH = 256,
   parameter int IDX_W      = 4,
   parameter int CFG_IDX    = 0,
   parameter int ADDR_IDX   = 1,
   parameter int BUF_IDX    = 15,
   localparam int FIFO_AW   = $clog2(FIFO_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit_i,
   input  logic [IDX_W-1:0]   commit_idx_i,
   input  logic [HOLD_W-1:0]  hold_i,
   input  logic [1:0]         rd_piece_i,
   output logic [HOLD_W-1:0]  rd_data_o,
   input  logic               fifo_we_i,
   input  logic [FIFO_AW-1:0] fifo_waddr_i,
   input  logic [FIFO_W-1:0]  fifo_wdata_i
);

   localparam int COEF_AW = $clog2(COEF_DEPTH);
   localparam int MAP_AW  = $clog2(MAP_DEPTH);
   localparam int AW_CM   = (COEF_AW > MAP_AW) ? COEF_AW : MAP_AW;
   localparam int AW      = (AW_CM > FIFO_AW) ? AW_CM : FIFO_AW;
   localparam int PIECES  = (COEF_W + HOLD_W - 1) / HOLD_W;
   localparam int RB_W    = PIECES * HOLD_W;

   // Elaboration-time parameter checks
   if (PIECES > 4) begin : g_chk_pieces
      $error("mem_tunnel: word select supports at most four pieces");
   end
   if (MAP_W > HOLD_W || FIFO_W > HOLD_W) begin : g_chk_narrow
      $error("mem_tunnel: narrow memories must fit one holding word");
   end
   if (AW > HOLD_W) begin : g_chk_aw
      $error("mem_tunnel: address must fit the holding word");
   end
   if (CFG_IDX == ADDR_IDX || CFG_IDX == BUF_IDX || ADDR_IDX == BUF_IDX) begin : g_chk_idx
      $error("mem_tunnel: commit indices must be distinct");
   end

   mem_cfg_t          cfg;
   logic [1:0]        wsel;
   logic [AW-1:0]     addr;
   logic [1:0]        coef_we;
   logic              map_we;
   logic [COEF_W-1:0] wdata;
   logic              rd_stb;
   logic [COEF_W-1:0] coef_rd [2];
   logic [MAP_W-1:0]  map_rd;
   logic [FIFO_W-1:0] fifo_rd;
   logic [RB_W-1:0]   rb_q;
   logic [RB_W-1:0]   rb_next;
   logic [HOLD_W-1:0] rb_piece [4];

   mt_ctrl #(
      .HOLD_W  (HOLD_W),
      .WIDE_W  (COEF_W),
      .AW      (AW),
      .IDX_W   (IDX_W),
      .CFG_IDX (CFG_IDX),
      .ADDR_IDX(ADDR_IDX),
      .BUF_IDX (BUF_IDX)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit_i),
      .idx_i    (commit_idx_i),
      .hold_i   (hold_i),
      .cfg_o    (cfg),
      .wsel_o   (wsel),
      .addr_o   (addr),
      .coef_we_o(coef_we),
      .map_we_o (map_we),
      .wdata_o  (wdata),
      .rd_stb_o (rd_stb)
   );

   for (genvar c = 0; c < 2; c++) begin : g_coef
      mt_ram #(.W(COEF_W), .DEPTH(COEF_DEPTH)) i_ram (
         .clk  (clk),
         .we   (coef_we[c]),
         .waddr(addr[COEF_AW-1:0]),
         .wdata(wdata),
         .raddr(addr[COEF_AW-1:0]),
         .rdata(coef_rd[c])
      );
   end

   mt_ram #(.W(MAP_W), .DEPTH(MAP_DEPTH)) i_map (
      .clk  (clk),
      .we   (map_we),
      .waddr(addr[MAP_AW-1:0]),
      .wdata(hold_i[MAP_W-1:0]),
      .raddr(addr[MAP_AW-1:0]),
      .rdata(map_rd)
   );

   mt_ram #(.W(FIFO_W), .DEPTH(FIFO_DEPTH)) i_fifo (
      .clk  (clk),
      .we   (fifo_we_i),
      .waddr(fifo_waddr_i),
      .wdata(fifo_wdata_i),
      .raddr(addr[FIFO_AW-1:0]),
      .rdata(fifo_rd)
   );

   always_comb begin
      case (cfg.tgt)
         TGT_COEF_I, TGT_COEF_IQ: rb_next = RB_W'(coef_rd[0]);
         TGT_COEF_Q:              rb_next = RB_W'(coef_rd[1]);
         TGT_MAP:                 rb_next = RB_W'(map_rd);
         TGT_FIFO:                rb_next = RB_W'(fifo_rd);
         default:                 rb_next = rb_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rb_q <= '0;
      else if (rd_stb) rb_q <= rb_next;
   end

   for (genvar p = 0; p < 4; p++) begin : g_rb
      if (p < PIECES) begin : g_live
         assign rb_piece[p] = rb_q[p*HOLD_W +: HOLD_W];
      end else begin : g_zero
         assign rb_piece[p] = '0;
      end
   end

   assign rd_data_o = rb_piece[rd_piece_i];

endmodule

// File: rtl/mem_tunnel_chk.sv
module mem_tunnel_chk #(
   parameter int IDX_W   = 4,
   parameter int HOLD_W  = 32,
   parameter int AW      = 8,
   parameter int RB_W    = 96,
   parameter int CFG_IDX = 0,
   parameter int BUF_IDX = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              commit_i,
   input logic [IDX_W-1:0]  commit_idx_i,
   input logic [HOLD_W-1:0] hold_i,
   input logic [1:0]        wsel,
   input logic [AW-1:0]     addr,
   input logic              auto_inc,
   input logic [1:0]        coef_we,
   input logic              map_we,
   input logic              rd_stb,
   input logic [RB_W-1:0]   rb
);

   assert_one_action_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|coef_we, map_we, rd_stb}));

   assert_wsel_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|coef_we) |=> (wsel == 2'd0));

   assert_wsel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && commit_idx_i == IDX_W'(CFG_IDX)) |=> (wsel == $past(hold_i[1:0])));

   assert_auto_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_inc && ((|coef_we) || map_we || rd_stb)) |=> (addr == AW'($past(addr) + 1'b1)));

   assert_manual_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_inc && commit_i && commit_idx_i == IDX_W'(BUF_IDX)) |=> (addr == $past(addr)));

   assert_rb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rb));

endmodule

bind mem_tunnel mem_tunnel_chk #(
   .IDX_W  (IDX_W),
   .HOLD_W (HOLD_W),
   .AW     (AW),
   .RB_W   (RB_W),
   .CFG_IDX(CFG_IDX),
   .BUF_IDX(BUF_IDX)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .commit_i    (commit_i),
   .commit_idx_i(commit_idx_i),
   .hold_i      (hold_i),
   .wsel        (wsel),
   .addr        (addr),
   .auto_inc    (cfg.auto_inc),
   .coef_we     (coef_we),
   .map_we      (map_we),
   .rd_stb      (rd_stb),
   .rb          (rb_q)
);

// File: tb/test_mem_tunnel.sv
`timescale 1ns/1ps
module test_mem_tunnel;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        commit_i;
   logic [3:0]  commit_idx_i;
   logic [31:0] hold_i;
   logic [1:0]  rd_piece_i;
   logic [31:0] rd_data_o;
   logic        fifo_we_i;
   logic [7:0]  fifo_waddr_i;
   logic [31:0] fifo_wdata_i;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [71:0] m_i   [64];
   logic [71:0] m_q   [64];
   logic [7:0]  m_map [256];
   logic [31:0] m_fifo[256];
   logic [31:0] asm0, asm1;

   always #4 clk = ~clk;

   mem_tunnel i_mem_tunnel (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_i    (commit_i),
      .commit_idx_i(commit_idx_i),
      .hold_i      (hold_i),
      .rd_piece_i  (rd_piece_i),
      .rd_data_o   (rd_data_o),
      .fifo_we_i   (fifo_we_i),
      .fifo_waddr_i(fifo_waddr_i),
      .fifo_wdata_i(fifo_wdata_i)
   );

   function automatic [31:0] cfgw(input bit au, input bit rd, input int t, input int ws);
      return {25'h0, au, rd, t[2:0], ws[1:0]};
   endfunction

   function automatic [31:0] exp_piece(input [71:0] e, input int p);
      case (p)
         0:       return e[31:0];
         1:       return e[63:32];
         2:       return {24'h0, e[71:64]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input [31:0] act, input [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic commit(input [3:0] idx, input [31:0] d);
      @(negedge clk);
      commit_i = 1'b1; commit_idx_i = idx; hold_i = d;
      @(negedge clk);
      commit_i = 1'b0;
   endtask

   task automatic check_entry(input string req, input [71:0] e);
      for (int p = 0; p < 4; p++) begin
         rd_piece_i = 2'(p);
         #0.5;
         check(req, rd_data_o, exp_piece(e, p));
      end
      rd_piece_i = 2'd0;
   endtask

   // Three pieces from word select 0; upper bits of piece 2 are random
   task automatic wr_wide(input [71:0] v);
      asm0 = v[31:0]; asm1 = v[63:32];
      commit(4'd15, v[31:0]);
      commit(4'd15, v[63:32]);
      commit(4'd15, {$urandom_range(32'hFFFFFF, 0), 8'h0} | {24'h0, v[71:64]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [71:0] v;
      int t, st, n, a, rt;
      void'($urandom(32'd4242));
      rst_n = 1'b0; commit_i = 1'b0; commit_idx_i = '0; hold_i = '0;
      rd_piece_i = '0; fifo_we_i = 1'b0; fifo_waddr_i = '0; fifo_wdata_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: readback empty after reset
      check_entry("R10", 72'h0);
      // R10/R1: reset config targets nothing, so buffer commit changes nothing
      commit(4'd15, 32'h1234_5678);
      check_entry("R10", 72'h0);

      // Producer fills the sample store
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         fifo_we_i = 1'b1; fifo_waddr_i = 8'(k); fifo_wdata_i = $urandom;
         m_fifo[k] = fifo_wdata_i;
      end
      @(negedge clk); fifo_we_i = 1'b0;

      // R2: manual write of one I entry, then read back
      commit(4'd0, cfgw(0, 0, 1, 0));
      commit(4'd1, 32'd9);
      v = 72'hA5_1122_3344_5566_7788; wr_wide(v); m_i[9] = v;
      commit(4'd0, cfgw(0, 1, 1, 0));
      commit(4'd1, 32'd9);
      commit(4'd15, 32'h0);
      check_entry("R2", m_i[9]);
      // R8: manual read again returns the same entry
      commit(4'd15, 32'h0);
      check_entry("R8", m_i[9]);
      // R11: other index leaves config and buffer alone
      commit(4'd7, 32'hFFFF_FFFF);
      check_entry("R11", m_i[9]);
      commit(4'd15, 32'h0);
      check_entry("R11", m_i[9]);

      // R3: start at word select 1, piece 0 keeps previous assembly
      commit(4'd0, cfgw(0, 0, 1, 1));
      commit(4'd1, 32'd10);
      commit(4'd15, 32'hDEAD_0001);
      commit(4'd15, 32'hFFFF_FF3C);
      m_i[10] = {8'h3C, 32'hDEAD_0001, asm0};
      asm1 = 32'hDEAD_0001;
      // R9: a write commit leaves the readback buffer unchanged
      check_entry("R9", m_i[9]);
      commit(4'd0, cfgw(0, 1, 1, 0));
      commit(4'd1, 32'd10);
      commit(4'd15, 32'h0);
      check_entry("R3", m_i[10]);

      // R1: unused target code writes nothing
      commit(4'd0, cfgw(0, 0, 6, 0));
      commit(4'd1, 32'd9);
      commit(4'd15, 32'h0); commit(4'd15, 32'h0); commit(4'd15, 32'h0);
      commit(4'd0, cfgw(0, 1, 1, 0));
      commit(4'd1, 32'd9);
      commit(4'd15, 32'h0);
      check_entry("R1", m_i[9]);

      // R6: sample store write ignored, address unmoved, reads advance
      commit(4'd0, cfgw(1, 0, 5, 0));
      commit(4'd1, 32'd2);
      commit(4'd15, 32'hDEAD_BEEF);
      commit(4'd0, cfgw(1, 1, 5, 0));
      commit(4'd15, 32'h0);
      check_entry("R6", {40'h0, m_fifo[2]});
      commit(4'd15, 32'h0);
      check_entry("R7", {40'h0, m_fifo[3]});

      // R8/R5: manual map writes overwrite the same address
      commit(4'd0, cfgw(0, 0, 4, 0));
      commit(4'd1, 32'd21); commit(4'd15, 32'hAB00_0099); m_map[21] = 8'h99;
      commit(4'd1, 32'd20); commit(4'd15, 32'h1200_0011); commit(4'd15, 32'h3400_0022);
      m_map[20] = 8'h22;
      commit(4'd0, cfgw(1, 1, 4, 0));
      commit(4'd1, 32'd20);
      commit(4'd15, 32'h0); check_entry("R8", {64'h0, m_map[20]});
      commit(4'd15, 32'h0); check_entry("R5", {64'h0, m_map[21]});

      // R7: wrap of coefficient address 63 -> 0 and map address 255 -> 0
      commit(4'd0, cfgw(1, 0, 1, 0));
      commit(4'd1, 32'd63);
      v = {$urandom, $urandom, $urandom}; wr_wide(v); m_i[63] = v;
      v = {$urandom, $urandom, $urandom}; wr_wide(v); m_i[0] = v;
      commit(4'd0, cfgw(1, 1, 1, 0));
      commit(4'd1, 32'd63);
      commit(4'd15, 32'h0); check_entry("R7", m_i[63]);
      commit(4'd15, 32'h0); check_entry("R7", m_i[0]);
      commit(4'd0, cfgw(1, 0, 4, 0));
      commit(4'd1, 32'd255);
      commit(4'd15, 32'h0000_00E1); m_map[255] = 8'hE1;
      commit(4'd15, 32'h0000_00E2); m_map[0] = 8'hE2;
      commit(4'd0, cfgw(1, 1, 4, 0));
      commit(4'd1, 32'd255);
      commit(4'd15, 32'h0); check_entry("R7", {64'h0, m_map[255]});
      commit(4'd15, 32'h0); check_entry("R7", {64'h0, m_map[0]});

      // Random bursts over I, Q, both and map (R2, R4, R5, R7, R9)
      for (int it = 0; it < 30; it++) begin
         t  = 1 + int'($urandom % 4);
         st = int'($urandom % 256);
         n  = 1 + int'($urandom % 4);
         commit(4'd0, cfgw(1, 0, t, 0));
         commit(4'd1, 32'(st));
         for (int k = 0; k < n; k++) begin
            a = (st + k) % 256;
            v = {$urandom, $urandom, $urandom};
            if (t == 4) begin
               commit(4'd15, v[31:0]);
               m_map[a] = v[7:0];
            end else begin
               wr_wide(v);
               if (t == 1 || t == 3) m_i[a % 64] = v;
               if (t == 2 || t == 3) m_q[a % 64] = v;
            end
         end
         for (int pass = 0; pass < ((t == 3) ? 2 : 1); pass++) begin
            rt = (t == 3) ? 1 + pass : t;
            commit(4'd0, cfgw(1, 1, rt, 0));
            commit(4'd1, 32'(st));
            for (int k = 0; k < n; k++) begin
               a = (st + k) % 256;
               commit(4'd15, 32'h0);
               if (rt == 4)      check_entry("R5", {64'h0, m_map[a]});
               else if (rt == 1) check_entry((t == 3) ? "R4" : "R2", m_i[a % 64]);
               else              check_entry((t == 3) ? "R4" : "R9", m_q[a % 64]);
            end
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule